// File: doc/BRIEF.md
# Frequency Lock Detector and Loop Selector

This block watches a recovered oscillator clock, already divided down to the parallel-word rate, and compares it with a reference clock. It counts oscillator cycles across a window of `2^WIN_LOG2` reference cycles. It decides whether the oscillator lies inside a ppm tolerance of the reference, and it drives a lock flag from that decision. The same decision picks which phase detector steers the loop. The phase-frequency detector drives the loop while the oscillator is being pulled toward the target rate. The bang-bang detector takes over once the rate is inside the window.

A two-bit mode input sets the behaviour. It can select automatic switching with a tight tolerance, automatic switching with a loose tolerance, or a forced choice of either detector. A rate input tells the block whether the reference runs at the word rate or at one quarter of it. In the quarter-rate case the oscillator count is prescaled by four, so both counts share one nominal value. The running oscillator count crosses into the reference domain through a toggle request/acknowledge pair, and each toggle is synchronised through two flops.

Top module: `flock_sel`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `lock_o` is 0. With `mode_sel` = 2'b00 or 2'b01, `bb_sel_o` is also 0 at that time.
- R2: A window measurement counts as in range when the oscillator count C over one window of N = 2^WIN_LOG2 reference cycles satisfies |C − N| ≤ floor(N·ppm/10^6).
- R3: The loose tolerance (PPM_LOOSE, 2000 by default) applies only when `mode_sel` = 2'b01. Every other mode uses the tight tolerance (PPM_TIGHT, 500 by default).
- R4: `lock_o` rises only after LOCK_RUN consecutive in-range windows (2 by default).
- R5: A single out-of-range window clears `lock_o`.
- R6: `lock_o` changes only when a window result arrives, which is within 16 reference cycles after a window boundary. It never changes in the middle of a window.
- R7: With `mode_sel` = 2'b00 or 2'b01, `bb_sel_o` follows `lock_o` one cycle later. A value of 1 selects the bang-bang detector and 0 selects the phase-frequency detector.
- R8: `mode_sel` = 2'b10 forces `bb_sel_o` to 0 and 2'b11 forces it to 1. Either takes effect one cycle after the mode is sampled, whatever the lock state, and `lock_o` keeps being computed.
- R9: `ref_rate_sel` = 1 counts every oscillator cycle, for a reference at the word rate. `ref_rate_sel` = 0 counts every fourth oscillator cycle, for a reference at one quarter of the word rate.
- R10: The first window after reset only seeds the measurement and yields no result. The earliest lock therefore comes just after the third window boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; windows, results and outputs are in this domain |
| rst | input | 1 | Synchronous active-high reset in the reference domain |
| osc_clk | input | 1 | Divided recovered-oscillator clock |
| mode_sel | input | 2 | 00 auto tight, 01 auto loose, 10 force PFD, 11 force bang-bang |
| ref_rate_sel | input | 1 | 1 = reference at word rate, 0 = reference at quarter rate |
| lock_o | output | 1 | Frequency lock flag |
| bb_sel_o | output | 1 | Detector select, 1 = bang-bang, 0 = phase-frequency |

## Verification
A window result lands a handful of cycles after each boundary at cycle k·N. That delay covers three oscillator flops, three reference flops and the result register. `lock_o` follows one cycle after the result, and `bb_sel_o` one cycle after that. The bench counts reference cycles from reset release and changes the oscillator period 50 cycles into a window. It samples lock results 300 cycles after a boundary, well past the result delay and far from the next window. Mode-forced selection is due one cycle after the mode changes, so it is read three cycles later. A mid-window read confirms that the lock flag holds until the boundary.

// File: rtl/flock_pkg.sv
`timescale 1ns/1ps
package flock_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO_TIGHT = 2'b00,
    MODE_AUTO_LOOSE = 2'b01,
    MODE_FORCE_PFD  = 2'b10,
    MODE_FORCE_BB   = 2'b11
  } flock_mode_e;

  // Allowed count deviation for a window of win cycles at ppm parts per million
  function automatic longint unsigned ppm_span(input longint unsigned win,
                                               input longint unsigned ppm);
    return (win * ppm) / 64'd1000000;
  endfunction

endpackage

// File: rtl/flock_osc_tally.sv
`timescale 1ns/1ps
module flock_osc_tally #(
  parameter int CW       = 19,
  parameter int PRE_LOG2 = 2
) (
  input  logic          osc_clk,
  input  logic          ref_rst,
  input  logic          rate_full,
  input  logic          req_tgl,
  output logic [CW-1:0] snap_q,
  output logic          ack_tgl
);

  logic [1:0]    rst_sy;
  logic          osc_rst;
  logic          tick;
  logic [CW-1:0] cnt_q;
  logic [2:0]    req_sy;

  // bring reset into the oscillator domain
  always_ff @(posedge osc_clk) rst_sy <= {rst_sy[0], ref_rst};
  assign osc_rst = rst_sy[1];

  generate
    if (PRE_LOG2 > 0) begin : g_pre
      logic [PRE_LOG2-1:0] pre_q;
      always_ff @(posedge osc_clk) begin
        if (osc_rst) pre_q <= '0;
        else         pre_q <= pre_q + 1'b1;
      end
      assign tick = rate_full | (&pre_q);
    end else begin : g_nopre
      logic unused_rate;
      assign unused_rate = rate_full;
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge osc_clk) begin
    if (osc_rst) begin
      cnt_q   <= '0;
      req_sy  <= '0;
      snap_q  <= '0;
      ack_tgl <= 1'b0;
    end else begin
      req_sy <= {req_sy[1:0], req_tgl};
      if (tick) cnt_q <= cnt_q + 1'b1;
      if (req_sy[2] ^ req_sy[1]) begin
        snap_q  <= cnt_q;
        ack_tgl <= ~ack_tgl;
      end
    end
  end

endmodule

// File: rtl/flock_ref_window.sv
`timescale 1ns/1ps
module flock_ref_window #(
  parameter int WIN_LOG2 = 16,
  parameter int CW       = 19,
  parameter int TOL_T    = 32,
  parameter int TOL_L    = 131
) (
  input  logic          ref_clk,
  input  logic          rst,
  input  logic [CW-1:0] snap_i,
  input  logic          ack_tgl_i,
  input  logic          loose_i,
  output logic          req_tgl_o,
  output logic          res_vld_o,
  output logic          res_in_o
);

  localparam logic [CW-1:0] NOM  = CW'(64'd1 << WIN_LOG2);
  localparam logic [CW-1:0] T_LO = NOM - CW'(TOL_T);
  localparam logic [CW-1:0] T_HI = NOM + CW'(TOL_T);
  localparam logic [CW-1:0] L_LO = NOM - CW'(TOL_L);
  localparam logic [CW-1:0] L_HI = NOM + CW'(TOL_L);

  logic [WIN_LOG2-1:0] win_q;
  logic [2:0]          ack_sy;
  logic                have_prev_q;
  logic [CW-1:0]       prev_q;
  logic [CW-1:0]       delta;
  logic                ack_edge;
  logic                in_tight;
  logic                in_loose;

  assign ack_edge = ack_sy[2] ^ ack_sy[1];
  assign delta    = snap_i - prev_q;
  assign in_tight = (delta >= T_LO) && (delta <= T_HI);
  assign in_loose = (delta >= L_LO) && (delta <= L_HI);

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      win_q       <= '0;
      req_tgl_o   <= 1'b0;
      ack_sy      <= '0;
      have_prev_q <= 1'b0;
      prev_q      <= '0;
      res_vld_o   <= 1'b0;
      res_in_o    <= 1'b0;
    end else begin
      win_q     <= win_q + 1'b1;
      ack_sy    <= {ack_sy[1:0], ack_tgl_i};
      res_vld_o <= 1'b0;
      if (&win_q) req_tgl_o <= ~req_tgl_o;
      if (ack_edge) begin
        prev_q      <= snap_i;
        have_prev_q <= 1'b1;
        if (have_prev_q) begin
          res_vld_o <= 1'b1;
          res_in_o  <= loose_i ? in_loose : in_tight;
        end
      end
    end
  end

endmodule

// File: rtl/flock_arbiter.sv
`timescale 1ns/1ps
module flock_arbiter
  import flock_pkg::*;
#(
  parameter int LOCK_RUN = 2
) (
  input  logic        ref_clk,
  input  logic        rst,
  input  logic        res_vld,
  input  logic        res_in,
  input  flock_mode_e mode,
  output logic        lock_o,
  output logic        bb_sel_o
);

  localparam int SW = $clog2(LOCK_RUN + 1);
  localparam logic [SW-1:0] RUN_TOP  = SW'(LOCK_RUN);
  localparam logic [SW-1:0] RUN_LAST = SW'(LOCK_RUN - 1);

  logic [SW-1:0] streak_q;

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      streak_q <= '0;
      lock_o   <= 1'b0;
    end else if (res_vld) begin
      if (!res_in) begin
        streak_q <= '0;
        lock_o   <= 1'b0;
      end else begin
        if (streak_q != RUN_TOP) streak_q <= streak_q + 1'b1;
        if (streak_q >= RUN_LAST) lock_o <= 1'b1;
      end
    end
  end

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      bb_sel_o <= 1'b0;
    end else begin
      case (mode)
        MODE_FORCE_PFD: bb_sel_o <= 1'b0;
        MODE_FORCE_BB:  bb_sel_o <= 1'b1;
        default:        bb_sel_o <= lock_o;
      endcase
    end
  end

endmodule

// File: rtl/flock_sel.sv
`timescale 1ns/1ps
module flock_sel
  import flock_pkg::*;
#(
  parameter int WIN_LOG2   = 16,
  parameter int PPM_TIGHT  = 500,
  parameter int PPM_LOOSE  = 2000,
  parameter int LOCK_RUN   = 2,
  parameter int PRE_LOG2   = 2
) (
  input  logic       ref_clk,
  input  logic       rst,
  input  logic       osc_clk,
  input  logic [1:0] mode_sel,
  input  logic       ref_rate_sel,
  output logic       lock_o,
  output logic       bb_sel_o
);

  localparam int CW    = WIN_LOG2 + 3;
  localparam int TOL_T = int'(ppm_span(64'd1 << WIN_LOG2, longint'(PPM_TIGHT)));
  localparam int TOL_L = int'(ppm_span(64'd1 << WIN_LOG2, longint'(PPM_LOOSE)));

  flock_mode_e   mode;
  logic          req_tgl;
  logic          ack_tgl;
  logic [CW-1:0] snap;
  logic          res_vld;
  logic          res_in;

  assign mode = flock_mode_e'(mode_sel);

  flock_osc_tally #(.CW(CW), .PRE_LOG2(PRE_LOG2)) tally_i (
    .osc_clk   (osc_clk),
    .ref_rst   (rst),
    .rate_full (ref_rate_sel),
    .req_tgl   (req_tgl),
    .snap_q    (snap),
    .ack_tgl   (ack_tgl)
  );

  flock_ref_window #(.WIN_LOG2(WIN_LOG2), .CW(CW), .TOL_T(TOL_T), .TOL_L(TOL_L)) win_i (
    .ref_clk   (ref_clk),
    .rst       (rst),
    .snap_i    (snap),
    .ack_tgl_i (ack_tgl),
    .loose_i   (mode == MODE_AUTO_LOOSE),
    .req_tgl_o (req_tgl),
    .res_vld_o (res_vld),
    .res_in_o  (res_in)
  );

  flock_arbiter #(.LOCK_RUN(LOCK_RUN)) arb_i (
    .ref_clk  (ref_clk),
    .rst      (rst),
    .res_vld  (res_vld),
    .res_in   (res_in),
    .mode     (mode),
    .lock_o   (lock_o),
    .bb_sel_o (bb_sel_o)
  );

endmodule

// File: rtl/flock_sel_chk.sv
`timescale 1ns/1ps
module flock_sel_chk (
  input logic       ref_clk,
  input logic       rst,
  input logic [1:0] mode_sel,
  input logic       lock_o,
  input logic       bb_sel_o,
  input logic       res_vld,
  input logic       res_in
);

  p_reset_clear_r1: assert property (@(posedge ref_clk) disable iff (rst)
    $past(rst) |-> !lock_o);

  p_rise_needs_in_r4: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(lock_o) |-> $past(res_vld && res_in));

  p_drop_on_out_r5: assert property (@(posedge ref_clk) disable iff (rst)
    (res_vld && !res_in) |=> !lock_o);

  p_fall_at_result_r6: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(lock_o) |-> $past(res_vld && !res_in));

  p_auto_follows_r7: assert property (@(posedge ref_clk) disable iff (rst)
    (!$past(rst) && !$past(mode_sel[1])) |-> (bb_sel_o == $past(lock_o)));

  p_forced_sel_r8: assert property (@(posedge ref_clk) disable iff (rst)
    (!$past(rst) && $past(mode_sel[1])) |-> (bb_sel_o == $past(mode_sel[0])));

endmodule

bind flock_sel flock_sel_chk chk_i (
  .ref_clk  (ref_clk),
  .rst      (rst),
  .mode_sel (mode_sel),
  .lock_o   (lock_o),
  .bb_sel_o (bb_sel_o),
  .res_vld  (res_vld),
  .res_in   (res_in)
);

// File: tb/flock_sel_tb_top.sv
`timescale 1ns/1ps
module flock_sel_tb_top;

  localparam int WL = 12;
  localparam int N  = 1 << WL;

  // vector: {mode[1:0], rate_code[1:0], exp_lock, exp_sel}
  // rate_code 0: exact, 1: +1000 ppm, 2: +1 %, 3: -1 %
  localparam int NV = 8;
  localparam logic [5:0] VEC [NV] = '{
    {2'b00, 2'd0, 1'b1, 1'b1},
    {2'b00, 2'd1, 1'b0, 1'b0},
    {2'b01, 2'd1, 1'b1, 1'b1},
    {2'b01, 2'd2, 1'b0, 1'b0},
    {2'b10, 2'd0, 1'b1, 1'b0},
    {2'b11, 2'd2, 1'b0, 1'b1},
    {2'b00, 2'd3, 1'b0, 1'b0},
    {2'b01, 2'd0, 1'b1, 1'b1}
  };

  logic       ref_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       ref_rate_sel = 1'b1;
  logic       lock_o;
  logic       bb_sel_o;

  realtime ref_per = 8.0;
  realtime osc_per = 8.0;
  int      cyc = 0;
  int      n_chk = 0;
  int      n_fail = 0;

  always #(ref_per / 2.0) ref_clk = ~ref_clk;
  always #(osc_per / 2.0) osc_clk = ~osc_clk;

  always @(posedge ref_clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  flock_sel #(.WIN_LOG2(WL)) dut_i (
    .ref_clk      (ref_clk),
    .rst          (rst),
    .osc_clk      (osc_clk),
    .mode_sel     (mode_sel),
    .ref_rate_sel (ref_rate_sel),
    .lock_o       (lock_o),
    .bb_sel_o     (bb_sel_o)
  );

  function automatic realtime per_of(input logic [1:0] code);
    case (code)
      2'd0:    return 8.0;
      2'd1:    return 7.992;
      2'd2:    return 7.92;
      default: return 8.08;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b want %b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    rst = 1'b1;
    repeat (6) @(negedge ref_clk);
    rst = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 8.0);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got running want finished");
    report();
    $finish;
  end

  initial begin
    // reset state, R1
    repeat (4) @(negedge ref_clk);
    chk("R1", "lock in reset", lock_o, 1'b0);
    chk("R1", "sel in reset", bb_sel_o, 1'b0);
    do_reset();
    @(negedge ref_clk);
    chk("R1", "lock after reset", lock_o, 1'b0);
    chk("R1", "sel after reset", bb_sel_o, 1'b0);

    // hysteresis and first-window seeding, R4 R10
    wait_to(2 * N + 300);
    chk("R10", "no lock after one result", lock_o, 1'b0);
    wait_to(3 * N + 300);
    chk("R4", "lock after two in-range windows", lock_o, 1'b1);
    chk("R7", "auto select follows lock", bb_sel_o, 1'b1);
    // mid-window change must not touch lock before the boundary, R6
    wait_to(3 * N + 400);
    osc_per = per_of(2'd2);
    wait_to(4 * N - 100);
    chk("R6", "lock held mid-window", lock_o, 1'b1);
    wait_to(4 * N + 300);
    chk("R5", "one bad window drops lock", lock_o, 1'b0);
    chk("R7", "auto select back to PFD", bb_sel_o, 1'b0);

    // table walk, R2 R3 R7 R8
    for (int i = 0; i < NV; i++) begin
      int w;
      w = 5 + 3 * i;
      wait_to(w * N + 50);
      mode_sel = VEC[i][5:4];
      osc_per  = per_of(VEC[i][3:2]);
      wait_to((w + 2) * N + 300);
      chk(VEC[i][5:4] == 2'b01 ? "R3" : "R2", "table lock", lock_o, VEC[i][1]);
      chk(VEC[i][5] ? "R8" : "R7", "table select", bb_sel_o, VEC[i][0]);
    end

    // forced selection is immediate and leaves lock alone, R8
    mode_sel = 2'b10;
    repeat (3) @(negedge ref_clk);
    chk("R8", "forced PFD select", bb_sel_o, 1'b0);
    chk("R8", "lock kept under force", lock_o, 1'b1);
    mode_sel = 2'b11;
    repeat (3) @(negedge ref_clk);
    chk("R8", "forced bang-bang select", bb_sel_o, 1'b1);
    mode_sel = 2'b00;
    repeat (3) @(negedge ref_clk);
    chk("R7", "auto select restored", bb_sel_o, 1'b1);

    // quarter-rate reference with prescale, R9
    ref_rate_sel = 1'b0;
    ref_per = 16.0;
    osc_per = 4.0;
    do_reset();
    wait_to(3 * N + 300);
    chk("R9", "quarter-rate reference locks", lock_o, 1'b1);
    chk("R9", "quarter-rate select", bb_sel_o, 1'b1);
    ref_rate_sel = 1'b1;
    do_reset();
    wait_to(3 * N + 300);
    chk("R9", "unprescaled count out of range", lock_o, 1'b0);

    report();
    $finish;
  end

endmodule